// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass

This block gives two clocked ports a private path around a FIFO. Each direction has one register that holds one word, the mailbox. Mailbox 1 carries a word from port A to port B, and mailbox 2 carries a word from port B to port A. The port that sends a word sees an active-low flag. The flag drops when the word is stored. It rises again once the other port has read the word and that read has been synchronized back into the sender's clock. Clocks `clk_a` and `clk_b` are free-running and need not be related.

A port accesses its mailbox only on a rising edge of its own clock, and only when its chip select is low, its enable is high and its mailbox select is high. A direction bit chooses a write or a read. The transfer width follows the port B bus size: 36, 18 or 9 bits, taken from the low end of the data bus. Data bits above the selected width read as zero. The accesses are single strobes with no valid/ready exchange. A sender applies back-pressure to itself by watching its flag, and the block drops any write made while the flag shows unread mail.

Top module: `mbx_bypass`

## Requirements
- R1: After reset, both flags `mb1_flag_n` and `mb2_flag_n` are high, and both `a_dout` and `b_dout` are zero.
- R2: A port A mailbox write is `a_cs_n`=0, `a_en`=1, `a_mbx`=1 and `a_wr`=1 on a `clk_a` edge. If `mb1_flag_n` is high at that edge, the write stores `a_din` and `mb1_flag_n` is low after that edge.
- R3: A mailbox write made while the sender's flag is low is ignored. The stored word keeps its earlier value.
- R4: A port B mailbox read is `b_cs_n`=0, `b_en`=1, `b_mbx`=1 and `b_wr`=0 on a `clk_b` edge. It loads mailbox 1, masked to the current width, into `b_dout` at that edge.
- R5: A port B read of mail that has reached the `clk_b` domain makes `mb1_flag_n` rise. This happens within three `clk_a` rising edges after the read edge.
- R6: `b_size` sets the width: 0 selects 36 bits, 1 selects 18 bits, and 2 or 3 selects 9 bits. Bits above the width read as zero on `b_dout`. A port B write stores only the low bits of `b_din` into mailbox 2.
- R7: Mailbox 2 mirrors mailbox 1. A port B write with `mb2_flag_n` high stores the word and drops `mb2_flag_n` after that `clk_b` edge. A port A read loads the word into `a_dout`. `mb2_flag_n` rises within three `clk_b` edges after that read.
- R8: A write with `cs_n` high, `en` low or `mbx` low leaves the flag high and the mailbox unchanged.
- R9: `a_dout` and `b_dout` hold their values on every edge that is not a mailbox read of their own port.
- R10: A read made when no unread mail is pending does not clear a later mail's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Full reset, active low, asynchronous assert |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data (mailbox 2) |
| mb1_flag_n | output | 1 | Mailbox 1 unread-mail flag, low = mail present, `clk_a` domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_size | input | 2 | Port B width: 0 = 36, 1 = 18, 2 or 3 = 9 |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data (mailbox 1) |
| mb2_flag_n | output | 1 | Mailbox 2 unread-mail flag, low = mail present, `clk_b` domain |

## Verification
Read data and the falling edge of the sender's flag are due one edge after the access. The bench drives on the falling edge of the access clock and samples at the next falling edge, so it reads the value that the register captured at the edge in between.

The rise of the flag crosses domains and has no fixed cycle. The bench therefore waits a bounded number of sender falling edges, up to four, and fails the check if the flag is still low after that.

Before each read, the bench waits three receiver edges after the write. This makes sure the mail has crossed, so that the read counts as the consuming read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    SZ_FULL    = 2'd0,
    SZ_HALF    = 2'd1,
    SZ_QUARTER = 2'd2,
    SZ_ALT_Q   = 2'd3
  } bus_size_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DW     = 36,
  parameter int STAGES = 2
) (
  input  logic          clk_s,
  input  logic          clk_r,
  input  logic          rst_n,
  input  logic          s_wr,
  input  logic [DW-1:0] s_din,
  output logic          s_full,
  input  logic          r_rd,
  output logic          r_pending,
  output logic [DW-1:0] r_word
);
  logic wr_tog, rd_tog, wr_tog_r, rd_tog_s;
  logic [DW-1:0] word_q;

  assign s_full    = wr_tog ^ rd_tog_s;
  assign r_pending = wr_tog_r ^ rd_tog;
  assign r_word    = word_q;

  always_ff @(posedge clk_s or negedge rst_n) begin
    if (!rst_n) begin
      wr_tog <= 1'b0;
      word_q <= '0;
    end else if (s_wr && !s_full) begin
      wr_tog <= ~wr_tog;
      word_q <= s_din;
    end
  end

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)                  rd_tog <= 1'b0;
    else if (r_rd && r_pending)  rd_tog <= ~rd_tog;
  end

  mbx_sync #(.STAGES(STAGES)) u_wr_to_r (
    .clk(clk_r), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_r));
  mbx_sync #(.STAGES(STAGES)) u_rd_to_s (
    .clk(clk_s), .rst_n(rst_n), .d(rd_tog), .q(rd_tog_s));
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int DW     = 36,
  parameter int STAGES = 2
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_en,
  input  logic          a_mbx,
  input  logic          a_wr,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          mb1_flag_n,
  input  logic          b_cs_n,
  input  logic          b_en,
  input  logic          b_mbx,
  input  logic          b_wr,
  input  logic [1:0]    b_size,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          mb2_flag_n
);
  localparam int HALF_W    = DW / 2;
  localparam int QUARTER_W = DW / 4;

  logic          a_acc, b_acc, a_mw, a_mr, b_mw, b_mr;
  logic          ch1_full, ch2_full, ch1_pend, ch2_pend;
  logic [DW-1:0] ch1_word, ch2_word, b_mask;

  assign a_acc = !a_cs_n && a_en && a_mbx;
  assign b_acc = !b_cs_n && b_en && b_mbx;
  assign a_mw  = a_acc && a_wr;
  assign a_mr  = a_acc && !a_wr;
  assign b_mw  = b_acc && b_wr;
  assign b_mr  = b_acc && !b_wr;

  always_comb begin
    unique case (bus_size_e'(b_size))
      SZ_FULL: b_mask = '1;
      SZ_HALF: b_mask = {{(DW-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: b_mask = {{(DW-QUARTER_W){1'b0}}, {QUARTER_W{1'b1}}};
    endcase
  end

  mbx_channel #(.DW(DW), .STAGES(STAGES)) u_ch_a2b (
    .clk_s(clk_a), .clk_r(clk_b), .rst_n(rst_n),
    .s_wr(a_mw), .s_din(a_din), .s_full(ch1_full),
    .r_rd(b_mr), .r_pending(ch1_pend), .r_word(ch1_word));

  mbx_channel #(.DW(DW), .STAGES(STAGES)) u_ch_b2a (
    .clk_s(clk_b), .clk_r(clk_a), .rst_n(rst_n),
    .s_wr(b_mw), .s_din(b_din & b_mask), .s_full(ch2_full),
    .r_rd(a_mr), .r_pending(ch2_pend), .r_word(ch2_word));

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n)    b_dout <= '0;
    else if (b_mr) b_dout <= ch1_word & b_mask;
  end

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n)    a_dout <= '0;
    else if (a_mr) a_dout <= ch2_word;
  end

  assign mb1_flag_n = ~ch1_full;
  assign mb2_flag_n = ~ch2_full;

  logic unused_pend;
  assign unused_pend = ch1_pend ^ ch2_pend;
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          a_cs_n,
  input logic          a_en,
  input logic          a_mbx,
  input logic          a_wr,
  input logic [DW-1:0] a_dout,
  input logic          mb1_flag_n,
  input logic          b_cs_n,
  input logic          b_en,
  input logic          b_mbx,
  input logic          b_wr,
  input logic [1:0]    b_size,
  input logic [DW-1:0] b_dout,
  input logic          mb2_flag_n
);
  logic a_w, a_r, b_w, b_r;
  assign a_w = !a_cs_n && a_en && a_mbx && a_wr;
  assign a_r = !a_cs_n && a_en && a_mbx && !a_wr;
  assign b_w = !b_cs_n && b_en && b_mbx && b_wr;
  assign b_r = !b_cs_n && b_en && b_mbx && !b_wr;

  p_flag1_set_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_w && mb1_flag_n) |=> !mb1_flag_n);
  p_flag1_no_stray_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (mb1_flag_n && !a_w) |=> mb1_flag_n);
  p_flag2_set_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_w && mb2_flag_n) |=> !mb2_flag_n);
  p_flag2_no_stray_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    (mb2_flag_n && !b_w) |=> mb2_flag_n);
  p_bdout_hold_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_r |=> $stable(b_dout));
  p_adout_hold_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_r |=> $stable(a_dout));
  p_mask_quarter_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_r && b_size[1]) |=> (b_dout[DW-1:DW/4] == '0));
  p_mask_half_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_r && b_size == 2'd1) |=> (b_dout[DW-1:DW/2] == '0));
endmodule

bind mbx_bypass mbx_bypass_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_en(a_en), .a_mbx(a_mbx), .a_wr(a_wr),
  .a_dout(a_dout), .mb1_flag_n(mb1_flag_n),
  .b_cs_n(b_cs_n), .b_en(b_en), .b_mbx(b_mbx), .b_wr(b_wr),
  .b_size(b_size), .b_dout(b_dout), .mb2_flag_n(mb2_flag_n));

// File: tb/mbx_bypass_tb.sv
module mbx_bypass_tb;
  localparam int CLK_A_NS = 10;
  localparam int CLK_B_NS = 14;
  localparam int DW = 36;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_en = 0, a_mbx = 0, a_wr = 0;
  logic b_cs_n = 1, b_en = 0, b_mbx = 0, b_wr = 0;
  logic [1:0] b_size = 0;
  logic [DW-1:0] a_din = 0, b_din = 0, a_dout, b_dout;
  logic mb1_flag_n, mb2_flag_n;
  int errors = 0, checks = 0;
  logic [DW-1:0] got;

  always #(CLK_A_NS/2) clk_a = ~clk_a;
  always #(CLK_B_NS/2) clk_b = ~clk_b;

  mbx_bypass u_dut (.*);

  function automatic logic [DW-1:0] exp_mask(logic [DW-1:0] d, logic [1:0] sz);
    if (sz == 2'd0) return d;
    if (sz == 2'd1) return d & {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
    return d & {{(DW-DW/4){1'b0}}, {(DW/4){1'b1}}};
  endfunction

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic wr, input logic [DW-1:0] d, input logic en, output logic [DW-1:0] q);
    @(negedge clk_a);
    a_cs_n = 0; a_en = en; a_mbx = 1; a_wr = wr; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_mbx = 0; a_wr = 0;
    q = a_dout;
  endtask

  task automatic b_op(input logic wr, input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk_b);
    b_cs_n = 0; b_en = 1; b_mbx = 1; b_wr = wr; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0; b_mbx = 0; b_wr = 0;
    q = b_dout;
  endtask

  task automatic wait_flag1_high(input string req);
    int n = 0;
    while (!mb1_flag_n && n < 4) begin @(negedge clk_a); n++; end
    check(mb1_flag_n, req, {35'd0, mb1_flag_n}, 36'd1);
  endtask

  task automatic wait_flag2_high(input string req);
    int n = 0;
    while (!mb2_flag_n && n < 4) begin @(negedge clk_b); n++; end
    check(mb2_flag_n, req, {35'd0, mb2_flag_n}, 36'd1);
  endtask

  task automatic cross_b(); repeat (3) @(negedge clk_b); endtask
  task automatic cross_a(); repeat (3) @(negedge clk_a); endtask

  task automatic round_a2b(input logic [DW-1:0] d, input logic [1:0] sz);
    logic [DW-1:0] q;
    @(negedge clk_b); b_size = sz;
    a_op(1'b1, d, 1'b1, q);
    check(!mb1_flag_n, "R2 flag1 low after write", {35'd0, mb1_flag_n}, 36'd0);
    cross_b();
    b_op(1'b0, '0, q);
    check(q == exp_mask(d, sz), "R4/R6 b_dout", q, exp_mask(d, sz));
    wait_flag1_high("R5 flag1 clears");
  endtask

  task automatic round_b2a(input logic [DW-1:0] d, input logic [1:0] sz);
    logic [DW-1:0] q;
    @(negedge clk_b); b_size = sz;
    b_op(1'b1, d, q);
    check(!mb2_flag_n, "R7 flag2 low after write", {35'd0, mb2_flag_n}, 36'd0);
    cross_a();
    a_op(1'b0, '0, 1'b1, q);
    check(q == exp_mask(d, sz), "R7/R6 a_dout", q, exp_mask(d, sz));
    wait_flag2_high("R7 flag2 clears");
  endtask

  initial begin
    #(CLK_A_NS * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] q, hold;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_a);
    // R1: reset state
    check(mb1_flag_n && mb2_flag_n, "R1 flags", {34'd0, mb1_flag_n, mb2_flag_n}, 36'd3);
    check(a_dout == 0 && b_dout == 0, "R1 douts", a_dout | b_dout, 36'd0);
    rst_n = 1;
    repeat (2) @(negedge clk_b);

    // R8: disabled write ignored
    a_op(1'b1, 36'hABCDE1234, 1'b0, q);
    repeat (2) @(negedge clk_a);
    check(mb1_flag_n, "R8 en low write", {35'd0, mb1_flag_n}, 36'd1);
    b_op(1'b0, '0, q);
    check(q == 0, "R8 mailbox unchanged", q, 36'd0);

    // R3: second write while full ignored
    a_op(1'b1, 36'h123456789, 1'b1, q);
    a_op(1'b1, 36'hFEDCBA987, 1'b1, q);
    cross_b();
    b_op(1'b0, '0, q);
    check(q == 36'h123456789, "R3 overwrite ignored", q, 36'h123456789);
    wait_flag1_high("R5 flag1 clears");

    // R9: b_dout holds across a port B write
    hold = b_dout;
    b_op(1'b1, 36'h000000055, q);
    check(q == hold, "R9 b_dout hold", q, hold);
    cross_a();
    a_op(1'b0, '0, 1'b1, q);
    check(q == 36'h55, "R7 a_dout", q, 36'h55);
    wait_flag2_high("R7 flag2 clears");

    // R10: idle read, then fresh mail keeps its flag low
    b_op(1'b0, '0, q);
    a_op(1'b1, 36'h0F0F0F0F0, 1'b1, q);
    repeat (8) @(negedge clk_a);
    check(!mb1_flag_n, "R10 no spurious clear", {35'd0, mb1_flag_n}, 36'd0);
    b_op(1'b0, '0, q);
    wait_flag1_high("R5 flag1 clears");

    // R6: directed widths
    round_a2b(36'hFFFFFFFFF, 2'd1);
    round_a2b(36'hFFFFFFFFF, 2'd3);
    round_b2a(36'hFFFFFFFFF, 2'd2);

    for (int i = 0; i < 30; i++) begin
      logic [DW-1:0] d = {$urandom(), $urandom()};
      logic [1:0] sz = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) round_a2b(d, sz);
      else round_b2a(d, sz);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule